// File: doc/BRIEF.md
# Phantom Clock Pattern-Unlock Interposer

This block sits in the read path between a CPU bus and a ROM. For ordinary software it is invisible: every access to the ROM window returns the ROM byte. Each strobed access is one bus cycle, and the block reads two things from the address bits. A high level on the direction bit marks a read and a low level marks a write. A second address bit carries one serial data bit. Writing a fixed 64-bit key, one bit per access, opens a short bit-serial window into a timekeeping register.

When the last key bit matches, the block captures the current calendar and time-of-day inputs into a 64-bit BCD word. The next 64 accesses each move one bit of that word. A read returns the bit at the current position on data bit 0. A write replaces that bit with the serial data bit. When the window closes, the block pulses a load strobe and presents the word, so that an external time counter can take over any values that were written. The counter itself is outside the block; the block only samples its fields.

Top module: `phantom_clk_tap`

## Requirements
- R1: After reset the block is disabled: `twr_o` is low and `data_o` equals `rom_data_i`.
- R2: While disabled, a strobed write (address bit 2 low) changes nothing. A strobed read (address bit 2 high) arms key matching with the key position at 0. In both cases the ROM byte is returned.
- R3: While armed, each strobed write compares address bit 0 with key bit k at the current position and advances on a match. Key bit k is bit k of 64'h5CA33AC55CA33AC5, so bytes C5, 3A, A3, 5C are each sent least significant bit first, and the sequence is sent twice. When bit 63 matches, the block is enabled with the position at 0.
- R4: A mismatched key bit returns the block to disabled. Later writes, including a complete key, are then ignored until a read re-arms the block.
- R5: A read while armed restarts matching at key bit 0, and the block stays armed.
- R6: On enabling, the time inputs are captured. While enabled, a strobed read returns the captured bit at the current position on `data_o[0]`, with all other data bits zero.
- R7: The captured word, from low to high bytes, holds hundredths, seconds, minutes, hours, day of week, day of month, month and year. Bits 7:6 of the hours byte read as zero (bit 7 is the 24-hour flag), and bits 7:4 of the day-of-week byte read as zero.
- R8: While enabled, a strobed write stores address bit 0 into the bit at the current position and returns 0. The position advances on every strobed access, and after the 64th access the block returns to disabled.
- R9: In the cycle after the 64th enabled access, `twr_o` is high for exactly one cycle and `twr_word_o` holds the word including every bit written in the window.
- R10: While disabled or armed, including during the key writes, `data_o` equals `rom_data_i`. Cycles with `acc_i` low change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | Access strobe, one cycle per ROM-window access |
| addr_i | input | 3 | Low address bits: bit 2 is read/write, bit 0 is serial data |
| rom_data_i | input | 8 | Data from the ROM |
| year_i | input | 8 | Two-digit year, BCD |
| month_i | input | 8 | Month, BCD |
| mday_i | input | 8 | Day of month, BCD |
| wday_i | input | 8 | Day of week 1 to 7; bits 7:4 are dropped |
| hour_i | input | 8 | Hour, BCD; bits 7:6 are dropped |
| min_i | input | 8 | Minutes, BCD |
| sec_i | input | 8 | Seconds, BCD |
| csec_i | input | 8 | Hundredths of a second, BCD |
| data_o | output | 8 | Data returned to the CPU |
| twr_o | output | 1 | One-cycle pulse when a transfer window closes |
| twr_word_o | output | 64 | Timekeeping word at the close of the window |

## Verification
`data_o` is combinational, so the response to an access is due in the same cycle as the strobe. The bench samples it just before the clock edge that commits the access. The state change caused by an access shows only in the response to the next strobed access. `twr_o` and `twr_word_o` are registered and are due in the cycle after the edge of the 64th enabled access, so the bench leaves that cycle idle and samples the pulse there, then samples again one cycle later to confirm it has dropped. Each expected response is queued by the driver when it issues the access, and the monitor compares it in that same cycle.

// File: rtl/phc_pkg.sv
package phc_pkg;
  localparam int TS_W   = 64;
  localparam int BYTE_W = 8;
  localparam logic [63:0] KEY_DEF = {2{32'h5CA33AC5}};

  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_ARM = 2'd1,
    ST_ON  = 2'd2
  } phc_st_e;
endpackage

// File: rtl/phc_seq.sv
module phc_seq
  import phc_pkg::*;
#(
  parameter int KEY_BITS = 64,
  parameter logic [KEY_BITS-1:0] KEY_PAT = KEY_DEF[KEY_BITS-1:0],
  parameter int XFER_BITS = TS_W,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             rd_i,
  input  logic             bit_i,
  output phc_st_e          st_o,
  output logic [CNT_W-1:0] ptr_o,
  output logic             cap_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] KEY_LAST  = CNT_W'(KEY_BITS - 1);
  localparam logic [CNT_W-1:0] XFER_LAST = CNT_W'(XFER_BITS - 1);

  phc_st_e          st_q, st_d;
  logic [CNT_W-1:0] ptr_q, ptr_d;
  logic             key_hit;

  assign key_hit = (bit_i == KEY_PAT[ptr_q]);

  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    cap_o  = 1'b0;
    done_o = 1'b0;
    if (acc_i) begin
      unique case (st_q)
        ST_OFF: begin
          if (rd_i) begin
            st_d  = ST_ARM;
            ptr_d = '0;
          end
        end
        ST_ARM: begin
          if (rd_i) begin
            ptr_d = '0;
          end else if (!key_hit) begin
            st_d  = ST_OFF;
            ptr_d = '0;
          end else if (ptr_q == KEY_LAST) begin
            st_d  = ST_ON;
            ptr_d = '0;
            cap_o = 1'b1;
          end else begin
            ptr_d = ptr_q + 1'b1;
          end
        end
        ST_ON: begin
          if (ptr_q == XFER_LAST) begin
            st_d   = ST_OFF;
            ptr_d  = '0;
            done_o = 1'b1;
          end else begin
            ptr_d = ptr_q + 1'b1;
          end
        end
        default: begin
          st_d  = ST_OFF;
          ptr_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_OFF;
      ptr_q <= '0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
    end
  end

  assign st_o  = st_q;
  assign ptr_o = ptr_q;
endmodule

// File: rtl/phc_time_reg.sv
module phc_time_reg
  import phc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             wr_en_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] ptr_i,
  input  logic             bit_i,
  input  logic [BYTE_W-1:0] year_i,
  input  logic [BYTE_W-1:0] month_i,
  input  logic [BYTE_W-1:0] mday_i,
  input  logic [BYTE_W-1:0] wday_i,
  input  logic [BYTE_W-1:0] hour_i,
  input  logic [BYTE_W-1:0] min_i,
  input  logic [BYTE_W-1:0] sec_i,
  input  logic [BYTE_W-1:0] csec_i,
  output logic             rd_bit_o,
  output logic             twr_o,
  output logic [TS_W-1:0]  twr_word_o
);
  localparam int N_FLD = TS_W / BYTE_W;

  logic [BYTE_W-1:0] fld [N_FLD];
  logic [TS_W-1:0]   ts_word;
  logic [TS_W-1:0]   sh_q, sh_d;
  logic              twr_q;
  logic [TS_W-1:0]   word_q;

  // byte order low to high is the register layout
  assign fld[0] = csec_i;
  assign fld[1] = sec_i;
  assign fld[2] = min_i;
  assign fld[3] = {2'b00, hour_i[5:0]};
  assign fld[4] = {4'h0, wday_i[3:0]};
  assign fld[5] = mday_i;
  assign fld[6] = month_i;
  assign fld[7] = year_i;

  for (genvar f = 0; f < N_FLD; f++) begin : g_fld
    assign ts_word[f*BYTE_W +: BYTE_W] = fld[f];
  end

  always_comb begin
    sh_d = sh_q;
    if (cap_i) begin
      sh_d = ts_word;
    end else if (wr_en_i) begin
      sh_d[ptr_i] = bit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      twr_q  <= 1'b0;
      word_q <= '0;
    end else begin
      sh_q  <= sh_d;
      twr_q <= done_i;
      if (done_i) word_q <= sh_d;
    end
  end

  assign rd_bit_o   = sh_q[ptr_i];
  assign twr_o      = twr_q;
  assign twr_word_o = word_q;
endmodule

// File: rtl/phc_out_mux.sv
module phc_out_mux #(
  parameter int DATA_W = 8
) (
  input  logic              on_i,
  input  logic              rd_i,
  input  logic              clk_bit_i,
  input  logic [DATA_W-1:0] rom_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    if (on_i) data_o = {{(DATA_W-1){1'b0}}, rd_i & clk_bit_i};
    else      data_o = rom_i;
  end
endmodule

// File: rtl/phantom_clk_tap.sv
module phantom_clk_tap
  import phc_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int RD_BIT   = 2,
  parameter int DAT_BIT  = 0,
  parameter int DATA_W   = 8,
  parameter int KEY_BITS = 64,
  parameter logic [KEY_BITS-1:0] KEY_PAT = KEY_DEF[KEY_BITS-1:0]
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] rom_data_i,
  input  logic [7:0]        year_i,
  input  logic [7:0]        month_i,
  input  logic [7:0]        mday_i,
  input  logic [7:0]        wday_i,
  input  logic [7:0]        hour_i,
  input  logic [7:0]        min_i,
  input  logic [7:0]        sec_i,
  input  logic [7:0]        csec_i,
  output logic [DATA_W-1:0] data_o,
  output logic              twr_o,
  output logic [63:0]       twr_word_o
);
  localparam int MAX_LEN = (KEY_BITS > TS_W) ? KEY_BITS : TS_W;
  localparam int CNT_W   = $clog2(MAX_LEN);

  phc_st_e          st;
  logic [CNT_W-1:0] ptr;
  logic             rd, sbit, cap, done, wr_en, clk_bit, on;

  assign rd    = addr_i[RD_BIT];
  assign sbit  = addr_i[DAT_BIT];
  assign on    = (st == ST_ON);
  assign wr_en = acc_i & ~rd & on;

  phc_seq #(
    .KEY_BITS (KEY_BITS),
    .KEY_PAT  (KEY_PAT),
    .XFER_BITS(TS_W),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .acc_i (acc_i),
    .rd_i  (rd),
    .bit_i (sbit),
    .st_o  (st),
    .ptr_o (ptr),
    .cap_o (cap),
    .done_o(done)
  );

  phc_time_reg #(
    .CNT_W(CNT_W)
  ) u_treg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .wr_en_i   (wr_en),
    .done_i    (done),
    .ptr_i     (ptr),
    .bit_i     (sbit),
    .year_i    (year_i),
    .month_i   (month_i),
    .mday_i    (mday_i),
    .wday_i    (wday_i),
    .hour_i    (hour_i),
    .min_i     (min_i),
    .sec_i     (sec_i),
    .csec_i    (csec_i),
    .rd_bit_o  (clk_bit),
    .twr_o     (twr_o),
    .twr_word_o(twr_word_o)
  );

  phc_out_mux #(
    .DATA_W(DATA_W)
  ) u_mux (
    .on_i     (on),
    .rd_i     (rd),
    .clk_bit_i(clk_bit),
    .rom_i    (rom_data_i),
    .data_o   (data_o)
  );
endmodule

// File: rtl/phc_chk.sv
module phc_chk
  import phc_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int RD_BIT   = 2,
  parameter int DAT_BIT  = 0,
  parameter int DATA_W   = 8,
  parameter int KEY_BITS = 64,
  parameter logic [KEY_BITS-1:0] KEY_PAT = KEY_DEF[KEY_BITS-1:0],
  parameter int CNT_W    = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rom_data_i,
  input logic [DATA_W-1:0] data_o,
  input logic              twr_o,
  input phc_st_e           st_i,
  input logic [CNT_W-1:0]  ptr_i
);
  localparam logic [CNT_W-1:0] XFER_LAST = CNT_W'(TS_W - 1);

  logic rd, sbit;
  assign rd   = addr_i[RD_BIT];
  assign sbit = addr_i[DAT_BIT];

  // R2
  off_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_OFF && acc_i && !rd) |=> (st_i == ST_OFF));

  // R4
  key_miss_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_ARM && acc_i && !rd && sbit != KEY_PAT[ptr_i]) |=> (st_i == ST_OFF));

  // R5
  arm_read_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_ARM && acc_i && rd) |=> (st_i == ST_ARM && ptr_i == '0));

  // R3
  unlock_ptr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_i == ST_ON) |-> (ptr_i == '0));

  // R8
  on_write_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_ON && acc_i && !rd) |-> (data_o == '0));

  // R8
  on_window_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_ON && acc_i && ptr_i == XFER_LAST) |=> (st_i == ST_OFF));

  // R9
  twr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    twr_o |=> !twr_o);

  // R10
  rom_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i != ST_ON) |-> (data_o == rom_data_i));

  // R10
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> ($stable(st_i) && $stable(ptr_i)));
endmodule

bind phantom_clk_tap phc_chk #(
  .ADDR_W  (ADDR_W),
  .RD_BIT  (RD_BIT),
  .DAT_BIT (DAT_BIT),
  .DATA_W  (DATA_W),
  .KEY_BITS(KEY_BITS),
  .KEY_PAT (KEY_PAT),
  .CNT_W   (CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .acc_i     (acc_i),
  .addr_i    (addr_i),
  .rom_data_i(rom_data_i),
  .data_o    (data_o),
  .twr_o     (twr_o),
  .st_i      (st),
  .ptr_i     (ptr)
);

// File: tb/tb_phantom_clk_tap.sv
`timescale 1ns/1ps
module tb_phantom_clk_tap;
  localparam logic [63:0] KEY = 64'h5CA33AC55CA33AC5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [7:0]  rom_data_i = 8'h80;
  logic [7:0]  year_i, month_i, mday_i, wday_i, hour_i, min_i, sec_i, csec_i;
  logic [7:0]  data_o;
  logic        twr_o;
  logic [63:0] twr_word_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;
  logic [6:0] rcnt = '0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk_i = ~clk_i;

  phantom_clk_tap dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc_i), .addr_i(addr_i),
    .rom_data_i(rom_data_i), .year_i(year_i), .month_i(month_i),
    .mday_i(mday_i), .wday_i(wday_i), .hour_i(hour_i), .min_i(min_i),
    .sec_i(sec_i), .csec_i(csec_i), .data_o(data_o), .twr_o(twr_o),
    .twr_word_o(twr_word_o)
  );

  function automatic logic [63:0] exp_word();
    return {year_i, month_i, mday_i, 4'h0, wday_i[3:0], 2'b00, hour_i[5:0],
            min_i, sec_i, csec_i};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one strobed access; rom_exp selects ROM byte as expected response
  task automatic xfer(input logic rd, input logic b, input bit rom_exp,
                      input logic [7:0] exp, input string tag);
    @(negedge clk_i);
    rcnt++;
    acc_i = 1'b1;
    addr_i = {rd, 1'b0, b};
    rom_data_i = {1'b1, rcnt};
    exp_q.push_back(rom_exp ? {1'b1, rcnt} : exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk_i);
    acc_i = 1'b0;
  endtask

  task automatic send_key(input int n, input string tag);
    for (int i = 0; i < n; i++) xfer(1'b0, KEY[i], 1'b1, 8'h00, tag);
  endtask

  // monitor: compares the response in the cycle of the access
  initial begin
    forever begin
      @(negedge clk_i);
      #3;
      if (acc_i) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL scoreboard: actual %h expected none", data_o);
        end else begin
          chk(tag_q.pop_front(), {56'h0, data_o}, {56'h0, exp_q.pop_front()});
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] w;
    logic [63:0] wr_pat;
    year_i = 8'h24; month_i = 8'h07; mday_i = 8'h31; wday_i = 8'hF5;
    hour_i = 8'hE3; min_i = 8'h59; sec_i = 8'h48; csec_i = 8'h97;
    repeat (3) @(negedge clk_i);
    #3;
    chk("R1 reset data", {56'h0, data_o}, {56'h0, rom_data_i});
    chk("R1 reset twr", {63'h0, twr_o}, 64'h0);
    rst_ni = 1'b1;

    // R2: key without arming is ignored; the read after it still sees ROM
    send_key(64, "R2 unarmed key rom");
    xfer(1'b1, 1'b0, 1'b1, 8'h00, "R2 read after unarmed key");

    // R3, R6, R7: armed now; unlock and read all bits
    send_key(64, "R10 key send rom");
    w = exp_word();
    chk("R7 layout masks", w, 64'h24073105_23594897);
    for (int i = 0; i < 64; i++) xfer(1'b1, 1'b0, 1'b0, {7'h0, w[i]}, "R6 read bit");
    idle();
    #3;
    chk("R9 twr pulse", {63'h0, twr_o}, 64'h1);
    chk("R9 twr word", twr_word_o, w);
    idle();
    #3;
    chk("R9 twr drops", {63'h0, twr_o}, 64'h0);

    // R8: after window, disabled again
    xfer(1'b1, 1'b0, 1'b1, 8'h00, "R8 after window rom");

    // R5: partial key, read restarts, idle cycles between, then full key
    year_i = 8'h99; month_i = 8'h12; mday_i = 8'h01; wday_i = 8'h07;
    hour_i = 8'h00; min_i = 8'h00; sec_i = 8'h01; csec_i = 8'h00;
    send_key(20, "R5 partial key rom");
    xfer(1'b1, 1'b0, 1'b1, 8'h00, "R5 restart read rom");
    for (int i = 0; i < 64; i++) begin
      xfer(1'b0, KEY[i], 1'b1, 8'h00, "R10 key with gaps rom");
      if (i % 9 == 4) idle();
    end
    w = exp_word();
    wr_pat = 64'hF0E1_D2C3_B4A5_9687;
    // R8: alternate write and read; reads see captured bits
    for (int i = 0; i < 64; i++) begin
      if (i % 2 == 0) begin
        xfer(1'b0, wr_pat[i], 1'b0, 8'h00, "R8 write returns zero");
        w[i] = wr_pat[i];
      end else begin
        xfer(1'b1, 1'b0, 1'b0, {7'h0, w[i]}, "R6 mixed read bit");
      end
    end
    idle();
    #3;
    chk("R9 twr pulse mixed", {63'h0, twr_o}, 64'h1);
    chk("R9 twr word mixed", twr_word_o, w);

    // R4: mismatch, then a full key is ignored, then read shows ROM
    xfer(1'b1, 1'b0, 1'b1, 8'h00, "R4 arm read rom");
    send_key(10, "R4 prefix rom");
    xfer(1'b0, ~KEY[10], 1'b1, 8'h00, "R4 bad bit rom");
    send_key(64, "R4 key ignored rom");
    xfer(1'b1, 1'b0, 1'b1, 8'h00, "R4 read still rom");

    // R4: re-arm by that read, full key unlocks again
    send_key(64, "R4 rearm key rom");
    w = exp_word();
    xfer(1'b1, 1'b0, 1'b0, {7'h0, w[0]}, "R4 rearmed unlock bit0");
    idle();
    idle();
    #3;
    chk("R10 scoreboard drained", 64'(exp_q.size()), 64'h0);
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule